// File: doc/BRIEF.md
# Asymmetric Polarity Delay Filter

This block is a single-bit delay element with two latencies. One logic level, the slow level, reaches the output only after it has been present at the input for a programmed number of consecutive clock ticks. The opposite level, the fast level, reaches the output one tick after it appears at the input. The parameter `SLOW_HIGH` fixes at build time which level is the slow one.

When the fast level comes back before the programmed run of slow ticks is complete, the pending slow transition is dropped. A pulse of the slow level that is shorter than the delay therefore never reaches the output. This rejects glitches of one polarity only. The fast polarity is passed through with a fixed one-tick latency.

The delay value is 15 bits wide and is compared against a saturating run counter on every tick. Typical uses are glitch filtering on a status line, stretching one edge of a strobe, or modelling a line that releases quickly and asserts slowly.

Top module: `asym_delay_filter`

## Requirements
- R1: With a delay D of 2 or more, the output carries the slow level in the tick after the input has shown the slow level for D consecutive ticks (inclusive), and not earlier.
- R2: The fast level at the input appears at the output exactly one tick later, whatever the delay value.
- R3: A run of the slow level shorter than D ticks is swallowed completely and leaves the output at the fast level. With slow = high and D = 4, input bits 000011111111100000001000000 (first tick leftmost) give output bits 000000001111110000000000000.
- R4: With `SLOW_HIGH` = 1, high (1) is the slow level and low (0) is the fast level. With `SLOW_HIGH` = 0 the roles are swapped, and the complemented input of R3 gives the complemented output.
- R5: A synchronous active-high reset drives the output to the fast level and clears the run count, so slow ticks seen before the reset do not count toward D afterwards.
- R6: A delay value of 0 or 1 gives both levels a one-tick latency (output equals the input of the previous tick).
- R7: The delay accepts values up to 32767. The run count saturates and does not wrap, so a slow level held longer than D keeps the output at the slow level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every rising edge is one tick |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Data input |
| delay | input | 15 | Latency of the slow level in ticks |
| dout | output | 1 | Filtered, delayed data output |

## Verification
Every result of this block is due at the output one tick after the input that decides it. For a fast input, that input tick alone decides the result. For a slow input, the tick that completes a run of D slow ticks decides it. For reset, the tick on which reset is sampled decides it. The bench drives each input on a falling edge and advances its behavioural model one tick. It then waits past the next rising edge and compares both polarity variants against the model in the middle of the high phase, so every comparison lands on the cycle in which the single output register has updated. The recorded output of the R3 pattern is also compared bit by bit against the expected string, one tick offset. This gives a check that does not depend on the model.

// File: rtl/apd_pkg.sv
package apd_pkg;

    localparam int unsigned DLY_W   = 15;
    localparam int unsigned DLY_MAX = (1 << DLY_W) - 1;

    typedef logic [DLY_W-1:0] dly_t;

    // per-tick view of the input after polarity mapping
    typedef struct packed {
        logic slow;   // input currently shows the slow level
        dly_t run;    // length of the slow run including this tick
    } run_view_t;

    // saturating increment of a run length
    function automatic dly_t run_inc(input dly_t cur);
        if (cur == dly_t'(DLY_MAX))
            return cur;
        return cur + dly_t'(1);
    endfunction

    // delays of zero behave as one tick
    function automatic dly_t eff_delay(input dly_t d);
        return (d == '0) ? dly_t'(1) : d;
    endfunction

endpackage

// File: rtl/apd_level_map.sv
module apd_level_map #(
    parameter bit SLOW_HIGH = 1'b1
) (
    input  logic din,
    input  logic slow_q,
    output logic is_slow,
    output logic dout
);
    generate
        if (SLOW_HIGH) begin : g_slow_high
            assign is_slow = din;
            assign dout    = slow_q;
        end else begin : g_slow_low
            assign is_slow = ~din;
            assign dout    = ~slow_q;
        end
    endgenerate
endmodule

// File: rtl/apd_run_counter.sv
module apd_run_counter
    import apd_pkg::*;
#(
    parameter int unsigned W = DLY_W
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      is_slow,
    output run_view_t view
);
    localparam logic [W-1:0] RUN_TOP = {W{1'b1}};

    dly_t run_q;

    always_comb begin
        view.slow = is_slow;
        view.run  = is_slow ? run_inc(run_q) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            run_q <= '0;
        else
            run_q <= view.run;
    end

    AST_RUN_RESTART: assert property (@(posedge clk) disable iff (rst)
        !$past(is_slow) && !$past(rst) |-> run_q == '0);  // R3

    AST_RUN_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        $past(is_slow) && $past(run_q) == RUN_TOP && !$past(rst) |-> run_q == RUN_TOP);  // R7

    AST_RUN_CLEARED: assert property (@(posedge clk)
        $past(rst) |-> run_q == '0);  // R5
endmodule

// File: rtl/apd_out_stage.sv
module apd_out_stage
    import apd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  run_view_t view,
    input  dly_t      delay,
    output logic      slow_q
);
    logic reached;

    always_comb reached = view.slow && (view.run >= eff_delay(delay));

    always_ff @(posedge clk) begin
        if (rst)
            slow_q <= 1'b0;
        else
            slow_q <= reached;
    end

    AST_SLOW_AFTER_RUN: assert property (@(posedge clk) disable iff (rst)
        slow_q |-> $past(view.slow));  // R1

    AST_SHORT_DELAY_PASS: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(delay) <= dly_t'(1) && $past(view.slow) |-> slow_q);  // R6
endmodule

// File: rtl/asym_delay_filter.sv
module asym_delay_filter
    import apd_pkg::*;
#(
    parameter bit SLOW_HIGH = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             din,
    input  logic [DLY_W-1:0] delay,
    output logic             dout
);
    localparam logic FAST_LVL = ~SLOW_HIGH;

    logic      is_slow;
    logic      slow_q;
    run_view_t view;

    apd_level_map #(.SLOW_HIGH(SLOW_HIGH)) u_map (
        .din     (din),
        .slow_q  (slow_q),
        .is_slow (is_slow),
        .dout    (dout)
    );

    apd_run_counter #(.W(DLY_W)) u_run (
        .clk     (clk),
        .rst     (rst),
        .is_slow (is_slow),
        .view    (view)
    );

    apd_out_stage u_out (
        .clk    (clk),
        .rst    (rst),
        .view   (view),
        .delay  (delay),
        .slow_q (slow_q)
    );

    AST_FAST_ONE_TICK: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(din) == FAST_LVL |-> dout == FAST_LVL);  // R2

    AST_RESET_FAST: assert property (@(posedge clk)
        $past(rst) |-> dout == FAST_LVL);  // R5

    AST_POLARITY_SLOW: assert property (@(posedge clk) disable iff (rst)
        dout != FAST_LVL |-> $past(din) == SLOW_HIGH);  // R4
endmodule

// File: tb/asym_delay_filter_bench.sv
module asym_delay_filter_bench;
    localparam int RUN_MAX = 32767;

    logic        clk = 1'b0;
    logic        rst;
    logic        din_hi, din_lo;
    logic [14:0] dly;
    logic        dout_hi, dout_lo;

    int checks = 0;
    int fails  = 0;
    int run_hi = 0, run_lo = 0;
    logic exp_hi = 1'b0, exp_lo = 1'b1;

    always #10 clk = ~clk;  // 50 MHz

    asym_delay_filter #(.SLOW_HIGH(1'b1)) u_asym_delay_filter (
        .clk(clk), .rst(rst), .din(din_hi), .delay(dly), .dout(dout_hi));

    asym_delay_filter #(.SLOW_HIGH(1'b0)) u_asym_delay_filter_lo (
        .clk(clk), .rst(rst), .din(din_lo), .delay(dly), .dout(dout_lo));

    task automatic check(input logic got, input logic exp, input string what);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b at %0t", what, got, exp, $time);
        end
    endtask

    // one tick: drive at the falling edge, compare after the rising edge
    task automatic step(input logic a, input logic b, input string tag);
        int eff;
        din_hi = a;
        din_lo = b;
        eff = (dly == 0) ? 1 : int'(dly);
        if (rst) begin
            run_hi = 0; run_lo = 0; exp_hi = 1'b0; exp_lo = 1'b1;
        end else begin
            run_hi = a ? ((run_hi < RUN_MAX) ? run_hi + 1 : run_hi) : 0;
            run_lo = !b ? ((run_lo < RUN_MAX) ? run_lo + 1 : run_lo) : 0;
            exp_hi = (a && run_hi >= eff) ? 1'b1 : 1'b0;
            exp_lo = (!b && run_lo >= eff) ? 1'b0 : 1'b1;
        end
        @(posedge clk);
        #5;
        check(dout_hi, exp_hi, {tag, " slow-high"});
        check(dout_lo, exp_lo, {tag, " slow-low R4"});
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : stim
        logic [26:0] pat_in, pat_out, got_hi, got_lo;
        logic [7:0]  lfsr;
        rst = 1'b1; dly = 15'd4; din_hi = 1'b0; din_lo = 1'b1;
        @(negedge clk);
        // R5: reset holds fast level even with slow input
        step(1'b0, 1'b1, "R5 reset");
        step(1'b1, 1'b0, "R5 reset slow in");
        step(1'b1, 1'b0, "R5 reset slow in");
        rst = 1'b0;
        step(1'b0, 1'b1, "R5 after reset");
        step(1'b0, 1'b1, "R2 idle");

        // R3 reference pattern, delay 4
        pat_in  = 27'b000011111111100000001000000;
        pat_out = 27'b000000001111110000000000000;
        got_hi = '0; got_lo = '1;
        for (int t = 0; t < 27; t++) begin
            step(pat_in[26-t], ~pat_in[26-t], "R3 pattern");
            if (t < 26) begin
                got_hi[26-(t+1)] = dout_hi;
                got_lo[26-(t+1)] = dout_lo;
            end
        end
        for (int t = 1; t < 27; t++) begin
            check(got_hi[26-t], pat_out[26-t], "R3 expected string slow-high");
            check(got_lo[26-t], ~pat_out[26-t], "R4 complemented string slow-low");
        end

        // R1 / R2: delay 6, run of 5 swallowed, run of 6 passes
        dly = 15'd6;
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, "R3 run of 5");
        step(1'b0, 1'b1, "R2 fast return");
        for (int i = 0; i < 6; i++) step(1'b1, 1'b0, "R1 run of 6");
        check(dout_hi, 1'b1, "R1 slow after exactly 6");
        check(dout_lo, 1'b0, "R1 slow after exactly 6 low");
        step(1'b0, 1'b1, "R2 fast one tick");
        check(dout_hi, 1'b0, "R2 fast after one tick");

        // R6: delay 0 and 1 pass both levels in one tick
        for (int d = 0; d < 2; d++) begin
            dly = 15'(d);
            for (int i = 0; i < 8; i++)
                step(i[0] ^ i[2], ~(i[0] ^ i[1]), "R6 short delay");
        end

        // R5: reset mid-run clears the count
        dly = 15'd5;
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, "R5 pre-reset run");
        rst = 1'b1;
        step(1'b1, 1'b0, "R5 reset mid-run");
        rst = 1'b0;
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, "R5 count restarted");
        check(dout_hi, 1'b0, "R5 count restarted, still fast");
        step(1'b1, 1'b0, "R5 run reaches 5");
        step(1'b0, 1'b1, "R2 idle");

        // R1 with pseudo-random stimulus, delay 2 and 3
        lfsr = 8'hA5;
        for (int i = 0; i < 300; i++) begin
            dly = (i < 150) ? 15'd2 : 15'd3;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            step(lfsr[0], lfsr[3], "R1 random");
        end
        step(1'b0, 1'b1, "R2 idle");

        // R7: maximum delay and saturation
        dly = 15'd32767;
        for (int i = 0; i < 32766; i++) step(1'b1, 1'b0, "R7 long run");
        check(dout_hi, 1'b0, "R7 one short of max");
        step(1'b1, 1'b0, "R7 max reached");
        check(dout_hi, 1'b1, "R7 slow at 32767");
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, "R7 saturated");
        step(1'b0, 1'b1, "R2 after long run");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule